// File: doc/BRIEF.md
# Indexed Segmented Vector Address Generator

This block turns one indexed vector memory instruction (a gather or a scatter, optionally segmented into several fields per element) into a stream of memory requests. Software-visible configuration arrives once with a `start` pulse: a base address, the width of the index values, the data element width and register-group multiplier taken from the vector type state, a field count, the element count (the current vector length), the first destination/source data register and an ordering flag. Index values then arrive one per element on a valid/ready stream. The register file read port that produces them is outside this block, so the index group layout stays with that fetch side.

For each element the block emits one request per field. The request carries a byte address, which is the base plus the zero-extended index plus the field number times the element size in bytes. It also carries the data register number and byte offset that hold that element of that field's register group. Requests leave on a valid/ready stream. While `req_valid` is high and `req_ready` is low, the request stays put. When no index is held, requests pause without any loss of progress. In ordered mode only one request may be in flight: the next one waits for a `cmp_valid` completion pulse.

Top module: `idx_seg_agu`

## Requirements
- R1: After reset, `busy`, `done`, `req_valid` and `idx_ready` are all low.
- R2: The request address is `base + zext(index) + field * 2^sew` modulo 2^AW. The index is taken from the low 8, 16, 32 or 64 bits of `idx_data` for `cfg_idx_w` codes 0, 1, 2 and 3. Higher bits are ignored. `cfg_sew` codes 0 to 3 give element sizes of 1, 2, 4 and 8 bytes.
- R3: Requests come out element by element in ascending order. Within an element, fields come out from 0 to `cfg_nf_m1`, and `cfg_nf_m1` holds the field count minus one. Each operation produces exactly `evl * (cfg_nf_m1 + 1)` requests, and `req_elem`/`req_field` name the current pair.
- R4: `req_vreg = (vd + field * 2^lmul + (elem * 2^sew) / VLENB) mod 32` and `req_byte = (elem * 2^sew) mod VLENB`. Here `cfg_lmul` codes 0 to 3 mean groups of 1, 2, 4 and 8 registers, and VLENB is VLEN/8.
- R5: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and every request field stays unchanged.
- R6: `req_valid` is asserted only while an index for the current element has been accepted. Holding `idx_valid` low stalls requests, and the sequence then resumes where it stopped.
- R7: With `cfg_ordered` set, no request is offered after a handshake until a `cmp_valid` pulse has been seen. `done` waits for the completion of the last request.
- R8: With `cfg_ordered` clear, the request after a non-last field of an element is offered in the very next cycle.
- R9: Exactly `evl` indices are accepted per operation. `idx_ready` is low when idle and once `evl` indices have been taken.
- R10: `done` is a single-cycle pulse, and `busy` is low while it is high. An operation with `evl = 0` raises `done` in the cycle after `start` without issuing any request.
- R11: `start` and the configuration inputs are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation, taken only when idle |
| cfg_base | input | AW | Base byte address |
| cfg_idx_w | input | 2 | Index width code (8 << code bits) |
| cfg_sew | input | 2 | Data element size code (1 << code bytes) |
| cfg_lmul | input | 2 | Data register group size code (1 << code registers) |
| cfg_nf_m1 | input | NF_W | Field count minus one |
| cfg_evl | input | EVL_W | Element count |
| cfg_ordered | input | 1 | One request in flight at a time |
| cfg_vd | input | RW | First data register |
| idx_valid | input | 1 | Index stream valid |
| idx_ready | output | 1 | Index stream ready |
| idx_data | input | 64 | Raw index value |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by memory side |
| req_addr | output | AW | Request byte address |
| req_vreg | output | RW | Data register of this element and field |
| req_byte | output | LB | Byte offset within that register |
| req_field | output | NF_W | Field number |
| req_elem | output | EVL_W | Element number |
| cmp_valid | input | 1 | Completion pulse for the request in flight (ordered mode) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished pulse |

## Verification
The assertions assume that `cmp_valid` pulses only for a request that is really in flight, never twice for the same request, and never in the cycle of the handshake that launches it. They also assume that the configuration is meaningful only in the cycle in which `start` is taken while idle. The stimulus raises `cmp_valid` only while its own model holds a request pending, at the earliest one cycle after the handshake. It changes the configuration pins and pulses `start` freely during a run, relying on R11, and it keeps `cfg_evl` within the index array it prepares.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    AG_IDLE  = 2'd0,
    AG_RUN   = 2'd1,
    AG_DRAIN = 2'd2
  } ag_state_e;

  localparam int IDX_RAW_W  = 64;
  localparam int N_IDX_WIDTHS = 4;

endpackage

// File: rtl/agu_idx_hold.sv
module agu_idx_hold
  import agu_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 want,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [IDX_RAW_W-1:0] in_data,
  input  logic [1:0]           iw,
  input  logic                 consume,
  output logic                 held_v,
  output logic [AW-1:0]        held_idx
);

  logic [IDX_RAW_W-1:0] raw_q;
  logic                 held_q;
  logic [IDX_RAW_W-1:0] lane [N_IDX_WIDTHS];

  assign in_ready = want && !held_q;
  assign held_v   = held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      raw_q  <= '0;
    end else if (clear) begin
      held_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      held_q <= 1'b1;
      raw_q  <= in_data;
    end else if (consume) begin
      held_q <= 1'b0;
    end
  end

  // one zero-extended candidate per supported index width
  for (genvar g = 0; g < N_IDX_WIDTHS; g++) begin : g_lane
    localparam int LW = 8 << g;
    if (LW >= IDX_RAW_W) begin : g_full
      assign lane[g] = raw_q;
    end else begin : g_part
      assign lane[g] = IDX_RAW_W'(raw_q[LW-1:0]);
    end
  end

  assign held_idx = AW'(lane[iw]);

endmodule

// File: rtl/agu_seq.sv
module agu_seq #(
  parameter int EVL_W = 16,
  parameter int NF_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [NF_W-1:0]  nf_m1,
  input  logic [EVL_W-1:0] evl,
  output logic [EVL_W-1:0] elem,
  output logic [NF_W-1:0]  field,
  output logic             last_field,
  output logic             last_elem
);

  logic [EVL_W-1:0] elem_q;
  logic [NF_W-1:0]  field_q;

  assign elem       = elem_q;
  assign field      = field_q;
  assign last_field = (field_q == nf_m1);
  assign last_elem  = (elem_q == evl - EVL_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_q  <= '0;
      field_q <= '0;
    end else if (clear) begin
      elem_q  <= '0;
      field_q <= '0;
    end else if (step) begin
      if (last_field) begin
        field_q <= '0;
        elem_q  <= elem_q + EVL_W'(1);
      end else begin
        field_q <= field_q + NF_W'(1);
      end
    end
  end

endmodule

// File: rtl/agu_addr.sv
module agu_addr #(
  parameter int AW    = 64,
  parameter int EVL_W = 16,
  parameter int NF_W  = 3,
  parameter int RW    = 5,
  parameter int LB    = 4
) (
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    idx,
  input  logic [NF_W-1:0]  field,
  input  logic [EVL_W-1:0] elem,
  input  logic [1:0]       sew,
  input  logic [1:0]       lmul,
  input  logic [RW-1:0]    vd,
  output logic [AW-1:0]    addr,
  output logic [RW-1:0]    vreg,
  output logic [LB-1:0]    byte_off
);

  localparam int FOFF_W = NF_W + 3;
  localparam int EOFF_W = EVL_W + 3;

  logic [FOFF_W-1:0] field_bytes;
  logic [FOFF_W-1:0] field_regs;
  logic [EOFF_W-1:0] elem_bytes;
  logic [EOFF_W-1:0] elem_regs;

  always_comb begin
    field_bytes = FOFF_W'(field) << sew;
    field_regs  = FOFF_W'(field) << lmul;
    elem_bytes  = EOFF_W'(elem) << sew;
    elem_regs   = elem_bytes >> LB;
    addr        = base + idx + AW'(field_bytes);
    vreg        = vd + RW'(field_regs) + RW'(elem_regs);
    byte_off    = elem_bytes[LB-1:0];
  end

endmodule

// File: rtl/idx_seg_agu.sv
module idx_seg_agu
  import agu_pkg::*;
#(
  parameter int AW    = 64,
  parameter int EVL_W = 16,
  parameter int VLEN  = 128,
  parameter int NF_W  = 3,
  parameter int RW    = 5,
  localparam int LB   = $clog2(VLEN / 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    cfg_base,
  input  logic [1:0]       cfg_idx_w,
  input  logic [1:0]       cfg_sew,
  input  logic [1:0]       cfg_lmul,
  input  logic [NF_W-1:0]  cfg_nf_m1,
  input  logic [EVL_W-1:0] cfg_evl,
  input  logic             cfg_ordered,
  input  logic [RW-1:0]    cfg_vd,
  input  logic             idx_valid,
  output logic             idx_ready,
  input  logic [63:0]      idx_data,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [AW-1:0]    req_addr,
  output logic [RW-1:0]    req_vreg,
  output logic [LB-1:0]    req_byte,
  output logic [NF_W-1:0]  req_field,
  output logic [EVL_W-1:0] req_elem,
  input  logic             cmp_valid,
  output logic             busy,
  output logic             done
);

  ag_state_e        state_q, state_n;
  logic [AW-1:0]    base_q;
  logic [1:0]       iw_q, sew_q, lmul_q;
  logic [NF_W-1:0]  nfm1_q;
  logic [EVL_W-1:0] evl_q;
  logic             ord_q;
  logic [RW-1:0]    vd_q;
  logic [EVL_W-1:0] fetched_q;
  logic             inflight_q;
  logic             done_q, done_n;

  logic             start_ok;
  logic             fire;
  logic             idx_hs;
  logic             want;
  logic             held_v;
  logic [AW-1:0]    held_idx;
  logic [EVL_W-1:0] elem;
  logic [NF_W-1:0]  field;
  logic             last_field;
  logic             last_elem;

  assign start_ok  = start && (state_q == AG_IDLE);
  assign want      = (state_q == AG_RUN) && (fetched_q != evl_q);
  assign req_valid = (state_q == AG_RUN) && held_v && !(ord_q && inflight_q);
  assign fire      = req_valid && req_ready;
  assign idx_hs    = idx_valid && idx_ready;
  assign busy      = (state_q != AG_IDLE);
  assign done      = done_q;
  assign req_field = field;
  assign req_elem  = elem;

  // configuration capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      iw_q   <= '0;
      sew_q  <= '0;
      lmul_q <= '0;
      nfm1_q <= '0;
      evl_q  <= '0;
      ord_q  <= 1'b0;
      vd_q   <= '0;
    end else if (start_ok) begin
      base_q <= cfg_base;
      iw_q   <= cfg_idx_w;
      sew_q  <= cfg_sew;
      lmul_q <= cfg_lmul;
      nfm1_q <= cfg_nf_m1;
      evl_q  <= cfg_evl;
      ord_q  <= cfg_ordered;
      vd_q   <= cfg_vd;
    end
  end

  always_comb begin
    state_n = state_q;
    done_n  = 1'b0;
    unique case (state_q)
      AG_IDLE: begin
        if (start_ok) begin
          if (cfg_evl == '0) done_n = 1'b1;
          else               state_n = AG_RUN;
        end
      end
      AG_RUN: begin
        if (fire && last_field && last_elem) begin
          if (ord_q) begin
            state_n = AG_DRAIN;
          end else begin
            state_n = AG_IDLE;
            done_n  = 1'b1;
          end
        end
      end
      AG_DRAIN: begin
        if (cmp_valid) begin
          state_n = AG_IDLE;
          done_n  = 1'b1;
        end
      end
      default: state_n = AG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= AG_IDLE;
      done_q     <= 1'b0;
      fetched_q  <= '0;
      inflight_q <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
      if (start_ok)    fetched_q <= '0;
      else if (idx_hs) fetched_q <= fetched_q + EVL_W'(1);
      if (start_ok)              inflight_q <= 1'b0;
      else if (fire && ord_q)    inflight_q <= 1'b1;
      else if (cmp_valid)        inflight_q <= 1'b0;
    end
  end

  agu_idx_hold #(.AW(AW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_ok),
    .want     (want),
    .in_valid (idx_valid),
    .in_ready (idx_ready),
    .in_data  (idx_data),
    .iw       (iw_q),
    .consume  (fire && last_field),
    .held_v   (held_v),
    .held_idx (held_idx)
  );

  agu_seq #(.EVL_W(EVL_W), .NF_W(NF_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_ok),
    .step       (fire),
    .nf_m1      (nfm1_q),
    .evl        (evl_q),
    .elem       (elem),
    .field      (field),
    .last_field (last_field),
    .last_elem  (last_elem)
  );

  agu_addr #(.AW(AW), .EVL_W(EVL_W), .NF_W(NF_W), .RW(RW), .LB(LB)) u_addr (
    .base     (base_q),
    .idx      (held_idx),
    .field    (field),
    .elem     (elem),
    .sew      (sew_q),
    .lmul     (lmul_q),
    .vd       (vd_q),
    .addr     (req_addr),
    .vreg     (req_vreg),
    .byte_off (req_byte)
  );

endmodule

// File: rtl/idx_seg_agu_chk.sv
module idx_seg_agu_chk #(
  parameter int AW    = 64,
  parameter int EVL_W = 16,
  parameter int NF_W  = 3,
  parameter int RW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             cfg_ordered,
  input logic [NF_W-1:0]  cfg_nf_m1,
  input logic             busy,
  input logic             done,
  input logic             idx_ready,
  input logic             req_valid,
  input logic             req_ready,
  input logic [AW-1:0]    req_addr,
  input logic [RW-1:0]    req_vreg,
  input logic [NF_W-1:0]  req_field,
  input logic [EVL_W-1:0] req_elem
);

  logic            ord_seen;
  logic [NF_W-1:0] nf_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ord_seen <= 1'b0;
      nf_seen  <= '0;
    end else if (start && !busy) begin
      ord_seen <= cfg_ordered;
      nf_seen  <= cfg_nf_m1;
    end
  end

  assert_hold_under_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid &&
      $stable({req_addr, req_vreg, req_field, req_elem}));

  assert_one_in_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ord_seen && req_valid && req_ready |=> !req_valid);

  assert_no_fetch_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !idx_ready);

  assert_req_only_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_field_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_field <= nf_seen);

endmodule

bind idx_seg_agu idx_seg_agu_chk #(
  .AW(AW), .EVL_W(EVL_W), .NF_W(NF_W), .RW(RW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .cfg_ordered (cfg_ordered),
  .cfg_nf_m1   (cfg_nf_m1),
  .busy        (busy),
  .done        (done),
  .idx_ready   (idx_ready),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_addr    (req_addr),
  .req_vreg    (req_vreg),
  .req_field   (req_field),
  .req_elem    (req_elem)
);

// File: tb/sim_idx_seg_agu.sv
`timescale 1ns/1ps
module sim_idx_seg_agu;
  localparam int AW = 64, EVL_W = 16, VLEN = 128, NF_W = 3, RW = 5;
  localparam int VLENB = VLEN / 8;
  localparam int LB = $clog2(VLENB);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [1:0] cfg_idx_w = '0, cfg_sew = '0, cfg_lmul = '0;
  logic [NF_W-1:0] cfg_nf_m1 = '0;
  logic [EVL_W-1:0] cfg_evl = '0;
  logic cfg_ordered = 1'b0;
  logic [RW-1:0] cfg_vd = '0;
  logic idx_valid = 1'b0, idx_ready;
  logic [63:0] idx_data = '0;
  logic req_valid, req_ready = 1'b0;
  logic [AW-1:0] req_addr;
  logic [RW-1:0] req_vreg;
  logic [LB-1:0] req_byte;
  logic [NF_W-1:0] req_field;
  logic [EVL_W-1:0] req_elem;
  logic cmp_valid = 1'b0, busy, done;

  int n_chk = 0, n_err = 0;
  logic [63:0] idx_arr [0:63];

  always #2.5 clk = ~clk;

  idx_seg_agu u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_addr(logic [63:0] b, logic [63:0] raw,
                                           int iw, int sew, int f);
    logic [63:0] ix;
    ix = (iw == 3) ? raw : (raw & ((64'd1 << (8 << iw)) - 64'd1));
    return b + ix + 64'(f << sew);
  endfunction

  function automatic int exp_vreg(int vd, int lmul, int sew, int e, int f);
    return (vd + f * (1 << lmul) + ((e << sew) / VLENB)) % 32;
  endfunction

  function automatic int exp_byte(int sew, int e);
    return (e << sew) % VLENB;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; idx_valid = 1'b0; req_ready = 1'b0; cmp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_op(input logic [63:0] base, input int iw, input int sew,
                        input int lmul, input int nfm1, input int evl,
                        input bit ord, input int vd, input int vpct,
                        input int rpct, input bit noise);
    int pushed = 0, eidx = 0, fidx = 0;
    bit pending = 0, prev_nonlast = 0, fire, ended = 0;
    for (int k = 0; k < 64; k++) idx_arr[k] = {$urandom, $urandom};
    @(negedge clk);
    cfg_base = base; cfg_idx_w = 2'(iw); cfg_sew = 2'(sew); cfg_lmul = 2'(lmul);
    cfg_nf_m1 = NF_W'(nfm1); cfg_evl = EVL_W'(evl); cfg_ordered = ord; cfg_vd = RW'(vd);
    start = 1'b1;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      start = noise && ($urandom % 6 == 0);   // R11: ignored while busy
      if (noise) begin
        cfg_base = {$urandom, $urandom}; cfg_evl = EVL_W'($urandom % 5);
        cfg_nf_m1 = NF_W'($urandom); cfg_sew = 2'($urandom); cfg_ordered = 1'($urandom);
      end
      idx_valid = (pushed < evl) && (($urandom % 100) < vpct);
      idx_data  = idx_arr[pushed % 64];
      req_ready = ($urandom % 100) < rpct;
      cmp_valid = pending && ($urandom % 2 == 0);
      #1;
      if (done) begin
        chk(eidx == evl, "R3", "requests elements at done", 64'(eidx), 64'(evl));
        chk(pushed == evl, "R9", "indices taken at done", 64'(pushed), 64'(evl));
        chk(!busy, "R10", "busy with done", 64'(busy), 64'd0);
        ended = 1;
        start = 1'b0; idx_valid = 1'b0; cmp_valid = 1'b0;
        break;
      end
      if (idx_ready && pushed >= evl) chk(0, "R9", "ready after evl indices", 64'(pushed), 64'(evl));
      if (prev_nonlast && !ord) chk(req_valid, "R8", "back-to-back field", 64'(req_valid), 64'd1);
      if (req_valid) begin
        chk(!pending, "R7", "request while in flight", 64'(req_valid), 64'd0);
        chk(pushed > eidx, "R6", "request without index", 64'(pushed), 64'(eidx + 1));
      end
      fire = req_valid && req_ready;
      if (cmp_valid) pending = 0;
      prev_nonlast = 0;
      if (fire) begin
        chk(req_elem == EVL_W'(eidx) && req_field == NF_W'(fidx), "R3", "elem/field order",
            {32'(req_elem), 32'(req_field)}, {32'(eidx), 32'(fidx)});
        chk(req_addr == exp_addr(base, idx_arr[eidx % 64], iw, sew, fidx), "R2", "address",
            req_addr, exp_addr(base, idx_arr[eidx % 64], iw, sew, fidx));
        chk(req_vreg == RW'(exp_vreg(vd, lmul, sew, eidx, fidx)) &&
            req_byte == LB'(exp_byte(sew, eidx)), "R4", "register map",
            {32'(req_vreg), 32'(req_byte)},
            {32'(exp_vreg(vd, lmul, sew, eidx, fidx)), 32'(exp_byte(sew, eidx))});
        if (ord) pending = 1;
        if (fidx == nfm1) begin fidx = 0; eidx++; end
        else begin fidx++; prev_nonlast = 1; end
      end else if (req_valid) begin
        // R5: must hold until taken
        @(posedge clk); #0.5;
        chk(req_valid && req_elem == EVL_W'(eidx) && req_field == NF_W'(fidx), "R5",
            "held request", {32'(req_elem), 32'(req_field)}, {32'(eidx), 32'(fidx)});
      end
      if (idx_valid && idx_ready) pushed++;
    end
    if (!ended) begin
      chk(0, "R10", "watchdog expired", 64'(eidx), 64'(evl));
      do_reset();
    end else begin
      @(negedge clk); #1;
      chk(!done && !busy, "R10", "done single pulse", {32'(done), 32'(busy)}, 64'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    #1;
    chk(!busy && !done && !req_valid && !idx_ready, "R1", "reset state",
        {busy, done, req_valid, idx_ready}, 64'd0);
    // directed corners
    run_op(64'h1000, 0, 2, 0, 0, 1, 0, 4, 100, 100, 0);             // single element
    run_op(64'hFFFF_FFFF_FFFF_FFF0, 3, 3, 3, 7, 6, 0, 0, 100, 100, 0); // R8 max fields, wrap
    run_op(64'h2000, 1, 1, 1, 2, 9, 1, 8, 100, 100, 0);             // R7 ordered
    run_op(64'h3000, 2, 0, 2, 1, 12, 0, 2, 15, 100, 0);             // R6 index stall
    run_op(64'h4000, 0, 3, 0, 3, 10, 0, 1, 100, 30, 0);             // R5 back-pressure
    run_op(64'h5000, 1, 2, 1, 1, 0, 0, 3, 100, 100, 0);             // R10 evl zero
    run_op(64'h6000, 2, 2, 1, 2, 8, 0, 6, 70, 70, 1);               // R11 start noise
    for (int n = 0; n < 40; n++) begin
      run_op({$urandom, $urandom}, $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 8,
             $urandom % 21, 1'($urandom), $urandom % 32, 30 + $urandom % 71,
             30 + $urandom % 71, 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule